// File: doc/BRIEF.md
# Sticky Floating-Point Exception Status Register

This block keeps the exception status that floating-point operations leave behind: invalid, overflow, underflow, inexact, divide-by-zero and denormal-flushed. Several functional units can finish in the same cycle. Each unit presents one update port: a write-enable that comes from the operation's guard, and a six-bit flag vector. The register takes the OR of all enabled updates with its present contents. The result becomes visible on the read port after the clock edge at which the matching results are written back.

A flag that has been set stays set. Only an explicit write, issued through its own port, can lower a flag. That write loads all six flags together with a two-bit rounding-mode field. The register stores the mode field and returns it unchanged; compute updates never touch it. When an explicit write and compute updates fall in the same cycle, the written value is taken as the base and the enabled updates are ORed onto it.

The read port is the register output itself. The state therefore appears with no extra cycle of delay.

Top module: `fx_sticky_status`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, both rd_flags and rd_mode read zero until the first enabled update or explicit write.
- R2: An update port k whose enable upd_en[k] is 1 sets every flag that is 1 in its slice upd_flags[6k+5:6k]. The new value is visible on rd_flags after the next rising clock edge. The flag bit positions are: 0 invalid, 1 overflow, 2 underflow, 3 inexact, 4 divide-by-zero, 5 denormal-flushed.
- R3: In a cycle with no explicit write, no flag that is 1 becomes 0.
- R4: An update port whose enable is 0 has no effect on any flag, whatever its flag slice holds.
- R5: When several ports are enabled in the same cycle, the new flags equal the old flags ORed with every enabled slice.
- R6: An explicit write (wr_en high) with no enabled updates loads rd_flags with wr_flags, which can clear set flags. It also loads rd_mode with wr_mode.
- R7: When an explicit write and enabled updates share a cycle, the new flags equal wr_flags ORed with every enabled slice. The old flags do not take part.
- R8: rd_mode changes only on an explicit write. Compute updates leave it unchanged.
- R9: rd_flags and rd_mode show the register state within the same cycle that follows the clock edge, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | N_PORTS | Per-port guard-derived update enable |
| upd_flags | input | 6*N_PORTS | Packed flag vectors, port k at bits 6k+5:6k |
| wr_en | input | 1 | Explicit write strobe |
| wr_flags | input | 6 | Flag value for an explicit write |
| wr_mode | input | 2 | Rounding-mode value for an explicit write |
| rd_flags | output | 6 | Current flag state |
| rd_mode | output | 2 | Current rounding-mode field |

## Verification
Every stored bit drives the read port directly. A wrong state therefore shows up on rd_flags or rd_mode in the cycle right after the faulty clock edge. Because the flags are sticky, a wrongly set bit then stays set until the next explicit write, so the scoreboard catches it in every later comparison. A lost bit shows up at once. Each expectation comes from a separate model that applies the explicit write first and then ORs in the enabled updates. This model covers disabled ports that carry all-ones flags, and writes that coincide with updates.

// File: rtl/fx_flag_pkg.sv
package fx_flag_pkg;

    localparam int FLAG_W = 6;
    localparam int MODE_W = 2;

    localparam int BIT_INVALID = 0;
    localparam int BIT_OVERFLOW = 1;
    localparam int BIT_UNDERFLOW = 2;
    localparam int BIT_INEXACT = 3;
    localparam int BIT_DIVZERO = 4;
    localparam int BIT_FLUSHED = 5;

    typedef logic [FLAG_W-1:0] flag_vec_t;
    typedef logic [MODE_W-1:0] mode_t;

endpackage

// File: rtl/fx_update_merge.sv
module fx_update_merge
    import fx_flag_pkg::*;
#(
    parameter int N_PORTS = 5,
    localparam int BUS_W = N_PORTS * FLAG_W
) (
    input  logic [N_PORTS-1:0] port_en,
    input  logic [BUS_W-1:0]   port_flags,
    output flag_vec_t          merged
);

    flag_vec_t gated [N_PORTS];

    // Each port contributes only when its guard-derived enable is high.
    for (genvar k = 0; k < N_PORTS; k++) begin : g_gate
        assign gated[k] = port_en[k] ? port_flags[k*FLAG_W +: FLAG_W] : '0;
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < N_PORTS; k++) begin
            merged = merged | gated[k];
        end
    end

endmodule

// File: rtl/fx_flag_core.sv
module fx_flag_core
    import fx_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_en,
    input  flag_vec_t load_flags,
    input  mode_t     load_mode,
    input  flag_vec_t set_flags,
    output flag_vec_t cur_flags,
    output mode_t     cur_mode
);

    flag_vec_t flags_q;
    flag_vec_t flags_d;
    mode_t     mode_q;
    mode_t     mode_d;

    // Base is the explicit value when loading, otherwise the held value;
    // compute updates are always ORed on top.
    always_comb begin
        flag_vec_t base;
        base    = load_en ? load_flags : flags_q;
        flags_d = base | set_flags;
        mode_d  = load_en ? load_mode : mode_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            mode_q  <= '0;
        end else begin
            flags_q <= flags_d;
            mode_q  <= mode_d;
        end
    end

    assign cur_flags = flags_q;
    assign cur_mode  = mode_q;

endmodule

// File: rtl/fx_sticky_status.sv
module fx_sticky_status
    import fx_flag_pkg::*;
#(
    parameter int N_PORTS = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_PORTS-1:0]        upd_en,
    input  logic [N_PORTS*FLAG_W-1:0] upd_flags,
    input  logic                      wr_en,
    input  logic [FLAG_W-1:0]         wr_flags,
    input  logic [MODE_W-1:0]         wr_mode,
    output logic [FLAG_W-1:0]         rd_flags,
    output logic [MODE_W-1:0]         rd_mode
);

    flag_vec_t merged_set;

    fx_update_merge #(.N_PORTS(N_PORTS)) u_merge (
        .port_en    (upd_en),
        .port_flags (upd_flags),
        .merged     (merged_set)
    );

    fx_flag_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (wr_en),
        .load_flags (wr_flags),
        .load_mode  (wr_mode),
        .set_flags  (merged_set),
        .cur_flags  (rd_flags),
        .cur_mode   (rd_mode)
    );

endmodule

// File: rtl/fx_sticky_status_chk.sv
module fx_sticky_status_chk
    import fx_flag_pkg::*;
#(
    parameter int N_PORTS = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_PORTS-1:0]        upd_en,
    input logic [N_PORTS*FLAG_W-1:0] upd_flags,
    input logic                      wr_en,
    input logic [FLAG_W-1:0]         wr_flags,
    input logic [MODE_W-1:0]         wr_mode,
    input logic [FLAG_W-1:0]         rd_flags,
    input logic [MODE_W-1:0]         rd_mode
);

    logic [FLAG_W-1:0] enabled_or;
    always_comb begin
        enabled_or = '0;
        for (int k = 0; k < N_PORTS; k++) begin
            if (upd_en[k]) enabled_or = enabled_or | upd_flags[k*FLAG_W +: FLAG_W];
        end
    end

    // R3: without an explicit write no set flag drops
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((rd_flags & $past(rd_flags)) == $past(rd_flags)));

    // R4: nothing enabled and no write leaves the flags unchanged
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && upd_en == '0) |=> $stable(rd_flags));

    // R5: merge of old value with all enabled slices
    a_r5_merge: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (rd_flags == ($past(rd_flags) | $past(enabled_or))));

    // R6: a plain explicit write loads the value
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && upd_en == '0) |=> (rd_flags == $past(wr_flags)));

    // R7: explicit write first, then enabled updates ORed on
    a_r7_write_then_or: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_flags == ($past(wr_flags) | $past(enabled_or))));

    // R8: mode held unless written
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_mode));

    // R8: mode loaded on write
    a_r8_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_mode == $past(wr_mode)));

endmodule

bind fx_sticky_status fx_sticky_status_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (upd_en),
    .upd_flags (upd_flags),
    .wr_en     (wr_en),
    .wr_flags  (wr_flags),
    .wr_mode   (wr_mode),
    .rd_flags  (rd_flags),
    .rd_mode   (rd_mode)
);

// File: tb/tb_fx_sticky_status.sv
`timescale 1ns/1ps
module tb_fx_sticky_status;

    localparam int NP = 5;
    localparam int FW = 6;
    localparam int MW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     upd_en = '0;
    logic [NP*FW-1:0]  upd_flags = '0;
    logic              wr_en = 1'b0;
    logic [FW-1:0]     wr_flags = '0;
    logic [MW-1:0]     wr_mode = '0;
    logic [FW-1:0]     rd_flags;
    logic [MW-1:0]     rd_mode;

    always #2.5 clk = ~clk;

    fx_sticky_status #(.N_PORTS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_flags(upd_flags),
        .wr_en(wr_en), .wr_flags(wr_flags), .wr_mode(wr_mode),
        .rd_flags(rd_flags), .rd_mode(rd_mode)
    );

    typedef struct {
        logic [FW-1:0] flags;
        logic [MW-1:0] mode;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            errors = 0;
    logic [FW-1:0] m_flags = '0;
    logic [MW-1:0] m_mode = '0;
    bit            done = 0;

    function automatic logic [NP*FW-1:0] slot(int k, logic [FW-1:0] f);
        logic [NP*FW-1:0] v;
        v = '0;
        v[k*FW +: FW] = f;
        return v;
    endfunction

    task automatic check(string tag, logic [FW-1:0] af, logic [FW-1:0] ef,
                         logic [MW-1:0] am, logic [MW-1:0] em);
        checks++;
        if (af !== ef || am !== em) begin
            errors++;
            $display("FAIL %s: flags=%h mode=%0d expected flags=%h mode=%0d",
                     tag, af, am, ef, em);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the model result.
    task automatic step(string tag, logic [NP-1:0] en, logic [NP*FW-1:0] fl,
                        logic we, logic [FW-1:0] wf, logic [MW-1:0] wm);
        exp_t e;
        logic [FW-1:0] base;
        @(negedge clk);
        upd_en = en; upd_flags = fl; wr_en = we; wr_flags = wf; wr_mode = wm;
        base = we ? wf : m_flags;
        for (int k = 0; k < NP; k++) if (en[k]) base = base | fl[k*FW +: FW];
        m_flags = base;
        if (we) m_mode = wm;
        @(posedge clk);
        #1;
        e.flags = m_flags; e.mode = m_mode; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares queued expectations away from the clock edge.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, rd_flags, e.flags, rd_mode, e.mode);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", rd_flags, '0, rd_mode, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rd_flags, '0, rd_mode, '0);

        step("R2 port0 invalid", 5'b00001, slot(0, 6'b000001), 0, '0, '0);
        step("R3 idle hold", '0, '0, 0, '0, '0);
        step("R4 disabled all-ones", 5'b00000, {NP{6'h3F}}, 0, '0, '0);
        step("R5 two ports merged", 5'b10010,
             slot(1, 6'b000010) | slot(4, 6'b001000) | slot(3, 6'b100000), 0, '0, '0);
        step("R3 zero-valued update", 5'b11111, '0, 0, '0, '0);
        step("R6 write clears", '0, {NP{6'h3F}}, 1, 6'b000000, 2'd2);
        step("R7 write plus update", 5'b00001, slot(0, 6'b010000), 1, 6'b000100, 2'd2);
        step("R8 updates keep mode", 5'b11111, {NP{6'b100000}}, 0, '0, 2'd3);
        step("R6 write all ones", 5'b00000, {NP{6'h3F}}, 1, 6'h3F, 2'd1);
        step("R7 write zero with updates", 5'b01000, slot(3, 6'b000100) | slot(2, 6'b000001),
             1, 6'b000000, 2'd0);

        // R9: new state is readable right after the edge
        @(negedge clk);
        upd_en = 5'b00100; upd_flags = slot(2, 6'b000001); wr_en = 0;
        @(posedge clk);
        #0.5;
        check("R9 no read delay", rd_flags, 6'b000101, rd_mode, 2'd0);
        m_flags = 6'b000101;
        step("R4 single port off", 5'b11011, slot(2, 6'b111010), 0, '0, '0);
        step("R5 last port", 5'b10000, slot(4, 6'b010000), 0, '0, '0);

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule